// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through and Level Flags

This block is a 9-bit word queue between two unrelated clock domains. A producer writes on its own clock, and a consumer reads on a second clock. The number of entries is a power-of-two parameter. Write and read positions cross between the domains as Gray-coded pointers through two-stage synchronizers. Each side therefore judges the fill level from its own position and a slightly stale copy of the other side's position. That stale view is always conservative.

Two read behaviours are chosen while reset is held.

- **Standard mode:** the consumer asserts a read enable to fetch a word into the registered output. The two domain flags then mean "not empty" and "not full".
- **Fall-through mode:** the head word moves into the output register by itself. The read-side flag means "output holds a valid word", and the write-side flag means "room for more". The word parked in the output register is not counted in the stored-word total. That total drives the level flags, so the queue holds one word more than the memory depth.

Three active-low level flags report the fill level:

- almost-empty, evaluated in the read domain;
- almost-full, evaluated in the write domain;
- more-than-half-full, evaluated in the write domain.

The two threshold offsets are loaded at reset. Each takes one of two parameter values, picked by a select input.

Top module: `dm_fifo`

## Requirements
- R1: In standard mode, a read enable at a read-clock edge, while `rflag_n` is high, loads the oldest stored word into `dout` at that edge. Words leave in the order they were written.
- R2: In fall-through mode, `rflag_n` low means `dout` holds the oldest word, presented without any read. A read enable at a read-clock edge while `rflag_n` is low consumes that word and lets the next one fall through.
- R3: While `rst_n` is low the queue empties. Afterwards `rflag_n` is low in standard mode and high in fall-through mode, `dout` is 0, `ae_n` is 0, and `af_n` and `hf_n` are 1.
- R4: In standard mode `wflag_n` is low exactly when DEPTH words are stored. In fall-through mode `wflag_n` is high exactly when DEPTH words are stored in memory, not counting the word in the output register.
- R5: A write attempted while the write-side flag reports no room stores nothing and is not read out later.
- R6: A read enable while nothing is available (standard: `rflag_n` low; fall-through: `rflag_n` high) moves no pointer and changes no flag.
- R7: `ae_n` is low while the stored-word count is at most the empty offset, and high above it.
- R8: `af_n` is low while the stored-word count is at least DEPTH minus the full offset.
- R9: `hf_n` is low while the stored-word count exceeds DEPTH/2.
- R10: Both offsets equal OFS_A when `ofs_sel` is 0 during reset, and OFS_B when it is 1.
- R11: In fall-through mode the stored-word count used by R4 and R7 to R9 excludes the word held in the output register. With one word written it is 0; with k ≥ 1 words present it is k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| fwft_sel | input | 1 | Sampled during reset: 1 selects fall-through mode |
| ofs_sel | input | 1 | Sampled during reset: picks OFS_B (1) or OFS_A (0) for both offsets |
| wen | input | 1 | Write request |
| din | input | 9 | Write data |
| ren | input | 1 | Read request |
| dout | output | 9 | Registered read data |
| wflag_n | output | 1 | Standard: low when full. Fall-through: low when there is room |
| rflag_n | output | 1 | Standard: low when empty. Fall-through: low when `dout` is valid |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | More than half full, active low |

## Verification
The bench steps the fill level one word at a time from empty to past capacity and back. It checks every flag once both domains have settled, in each mode and with each offset choice.

- A design that counted the output-register word would move every level flag one step early in fall-through mode, and would report full one word too soon.
- A design that took a write while full would return a stray word during the drain.
- A design that took a read while empty would shift every later word or wrap the count, upsetting the flags.

Random concurrent traffic then checks word order across the clock crossing.

// File: rtl/dmf_pkg.sv
// Shared constants and types for the dual-mode FIFO.
package dmf_pkg;
    localparam int WORD_W = 9;
    typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;
endpackage

// File: rtl/dmf_sync2.sv
// Two-stage synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock.
module dmf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the value through two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_wr_ctl.sv
// Write-domain control: write pointer, room flag, almost-full and half-full.
// Assumes rgray_s is the read pointer already synchronized into wclk.
module dmf_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int OFS_A = 7,
    parameter int OFS_B = 15
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          ofs_sel,
    input  logic          wen,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic          wflag_n,
    output logic          af_n,
    output logic          hf_n
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    dmf_pkg::fifo_mode_e mode_q;
    logic [CW-1:0] ofs_q;
    logic [CW-1:0] wbin, wbin_nxt, rbin_s, cnt;
    logic          full;

    // Latch the mode and full offset while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode_q <= fwft_sel ? dmf_pkg::MODE_FWFT : dmf_pkg::MODE_STD;
            ofs_q  <= ofs_sel ? CW'(OFS_B) : CW'(OFS_A);
        end
    end

    // Convert the synchronized Gray read pointer to binary.
    always_comb begin
        for (int i = 0; i < CW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    // Fill level and write acceptance.
    always_comb begin
        cnt      = wbin - rbin_s;
        full     = (cnt == DEPTH_C);
        wr_fire  = wen && !full;
        wbin_nxt = wbin + CW'(wr_fire);
    end

    // Advance the write pointer and its Gray image.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Drive the write-side flags.
    always_comb begin
        waddr   = wbin[AW-1:0];
        wflag_n = (mode_q == dmf_pkg::MODE_FWFT) ? full : !full;
        af_n    = !(cnt >= (DEPTH_C - ofs_q));
        hf_n    = !(cnt > HALF_C);
    end

    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen && (cnt == DEPTH_C)) |=> (wbin == $past(wbin)));

    a_r4_count_bound: assert property (@(posedge wclk) disable iff (!rst_n)
        cnt <= DEPTH_C);

    generate
        if (OFS_A < DEPTH / 2 && OFS_B < DEPTH / 2) begin : g_order
            a_r9_af_implies_hf: assert property (@(posedge wclk) disable iff (!rst_n)
                !af_n |-> !hf_n);
        end
    endgenerate
endmodule

// File: rtl/dmf_rd_ctl.sv
// Read-domain control: read pointer, fall-through output valid, read flag, almost-empty.
// Assumes wgray_s is the write pointer already synchronized into rclk.
module dmf_rd_ctl #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int OFS_A = 7,
    parameter int OFS_B = 15
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          ofs_sel,
    input  logic          ren,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          load,
    output logic          rflag_n,
    output logic          ae_n
);
    localparam int CW = AW + 1;

    dmf_pkg::fifo_mode_e mode_q;
    logic [CW-1:0] ofs_q;
    logic [CW-1:0] rbin, rbin_nxt, wbin_s, cnt;
    logic          mem_empty, ov, is_fwft;

    // Latch the mode and empty offset while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode_q <= fwft_sel ? dmf_pkg::MODE_FWFT : dmf_pkg::MODE_STD;
            ofs_q  <= ofs_sel ? CW'(OFS_B) : CW'(OFS_A);
        end
    end

    // Convert the synchronized Gray write pointer to binary.
    always_comb begin
        for (int i = 0; i < CW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    // Memory count (output register excluded) and fetch decision.
    always_comb begin
        is_fwft   = (mode_q == dmf_pkg::MODE_FWFT);
        cnt       = wbin_s - rbin;
        mem_empty = (cnt == '0);
        load      = is_fwft ? (!mem_empty && (!ov || ren)) : (ren && !mem_empty);
        rbin_nxt  = rbin + CW'(load);
    end

    // Advance the read pointer and track output-register validity.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            if (is_fwft && load)
                ov <= 1'b1;
            else if (ren)
                ov <= 1'b0;
        end
    end

    // Drive the read-side flags.
    always_comb begin
        raddr   = rbin[AW-1:0];
        rflag_n = is_fwft ? !ov : !mem_empty;
        ae_n    = !(cnt <= ofs_q);
    end

    a_r6_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (wbin_s == rbin) |=> (rbin == $past(rbin)));

    a_r2_valid_holds: assert property (@(posedge rclk) disable iff (!rst_n)
        (is_fwft && ov && !ren) |=> ov);

    a_r1_std_no_valid: assert property (@(posedge rclk) disable iff (!rst_n)
        !is_fwft |=> !ov);
endmodule

// File: rtl/dm_fifo.sv
// Dual-clock 9-bit FIFO with standard or fall-through read behaviour and level flags.
// Assumes DEPTH is a power of two and both offsets are below DEPTH.
module dm_fifo #(
    parameter int DEPTH = 64,
    parameter int OFS_A = 7,
    parameter int OFS_B = 15
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic                       fwft_sel,
    input  logic                       ofs_sel,
    input  logic                       wen,
    input  logic [dmf_pkg::WORD_W-1:0] din,
    input  logic                       ren,
    output logic [dmf_pkg::WORD_W-1:0] dout,
    output logic                       wflag_n,
    output logic                       rflag_n,
    output logic                       ae_n,
    output logic                       af_n,
    output logic                       hf_n
);
    localparam int AW = $clog2(DEPTH);

    logic [dmf_pkg::WORD_W-1:0] mem [DEPTH];
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wr_fire, load;

    dmf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .OFS_A(OFS_A), .OFS_B(OFS_B)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
        .wen(wen), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
        .wr_fire(wr_fire), .wflag_n(wflag_n), .af_n(af_n), .hf_n(hf_n)
    );

    dmf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .OFS_A(OFS_A), .OFS_B(OFS_B)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
        .ren(ren), .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr),
        .load(load), .rflag_n(rflag_n), .ae_n(ae_n)
    );

    dmf_sync2 #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dmf_sync2 #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    // Store accepted words.
    always_ff @(posedge wclk) begin
        if (wr_fire) mem[waddr] <= din;
    end

    // Load the output register on a fetch.
    always_ff @(posedge rclk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= mem[raddr];
    end

    a_r2_dout_stable: assert property (@(posedge rclk) disable iff (!rst_n)
        (!load) |=> $stable(dout));
endmodule

// File: tb/sim_dm_fifo.sv
`timescale 1ns/1ps
module sim_dm_fifo;
    localparam int DEPTH = 64;
    localparam int OFS_A = 7;
    localparam int OFS_B = 15;

    logic wclk = 0, rclk = 0, rst_n = 0, fwft_sel = 0, ofs_sel = 0, wen = 0, ren = 0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic wflag_n, rflag_n, ae_n, af_n, hf_n;

    int checks = 0, errors = 0;
    logic [8:0] q[$];
    bit mode_fwft;
    int ofs;

    dm_fifo #(.DEPTH(DEPTH), .OFS_A(OFS_A), .OFS_B(OFS_B)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ofs_sel(ofs_sel),
        .wen(wen), .din(din), .ren(ren), .dout(dout), .wflag_n(wflag_n),
        .rflag_n(rflag_n), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
    );

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    // Expected flags from the model's word total (R3 R4 R7 R8 R9 R10 R11).
    task automatic check_flags(string where);
        int sz = q.size();
        int mc = mode_fwft ? ((sz > 0) ? sz - 1 : 0) : sz;
        string ex = $sformatf("%s%s%s", where, ofs_sel ? " R10" : "", mode_fwft ? " R11" : "");
        chk({where, mode_fwft ? " R2" : " R1", " R3 rflag"}, int'(rflag_n),
            mode_fwft ? int'(sz == 0) : int'(sz != 0));
        chk({ex, " R4 wflag"}, int'(wflag_n), mode_fwft ? int'(mc == DEPTH) : int'(mc != DEPTH));
        chk({ex, " R7 ae"}, int'(ae_n), int'(!(mc <= ofs)));
        chk({ex, " R8 af"}, int'(af_n), int'(!(mc >= DEPTH - ofs)));
        chk({ex, " R9 hf"}, int'(hf_n), int'(!(mc > DEPTH / 2)));
    endtask

    task automatic do_write(logic [8:0] d);
        bit ok;
        @(negedge wclk);
        ok  = mode_fwft ? !wflag_n : wflag_n;
        wen = 1; din = d;
        @(negedge wclk);
        wen = 0;
        if (ok) q.push_back(d);
    endtask

    task automatic do_read();
        bit ok;
        @(negedge rclk);
        ok = mode_fwft ? !rflag_n : rflag_n;
        if (ok && q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6 read offered with model empty actual 1 expected 0");
            ok = 0;
        end
        if (ok && mode_fwft) chk("R2 fall-through head", int'(dout), int'(q[0]));
        ren = 1;
        @(negedge rclk);
        ren = 0;
        if (ok) begin
            if (mode_fwft) void'(q.pop_front());
            else chk("R1 R5 read data", int'(dout), int'(q.pop_front()));
        end
    endtask

    task automatic do_reset(bit f, bit o);
        wen = 0; ren = 0; rst_n = 0; fwft_sel = f; ofs_sel = o;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1;
        q.delete();
        mode_fwft = f;
        ofs = o ? OFS_B : OFS_A;
        settle();
        check_flags("reset");
        chk("R3 dout after reset", int'(dout), 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 2; o++) begin
                do_reset(m[0], o[0]);
                // R6: read with nothing available
                do_read();
                settle();
                check_flags("R6 empty read");
                // Step up through every level, past capacity (R5)
                for (int i = 0; i < DEPTH + 2; i++) begin
                    do_write(9'(i * 7 + o * 3 + m));
                    settle();
                    check_flags("fill");
                end
                // Step back down, checking data and flags
                while (q.size() > 0) begin
                    do_read();
                    settle();
                    check_flags("drain");
                end
                do_read();
                settle();
                check_flags("R6 extra read");
                // Concurrent random traffic across the crossing
                fork
                    begin
                        repeat (300) begin
                            if ($urandom % 3 != 0) do_write(9'($urandom));
                            else @(negedge wclk);
                        end
                    end
                    begin
                        repeat (300) begin
                            if ($urandom % 2 != 0) do_read();
                            else @(negedge rclk);
                        end
                    end
                join
                settle();
                check_flags("random");
                while (q.size() > 0) do_read();
                settle();
                check_flags("final drain");
            end
        end
        summary();
    end
endmodule